// File: doc/BRIEF.md
# Nibble-Bus Single-Byte Write Target

This block is the target side of a clocked 4-bit multiplexed bus on which a host moves single-byte writes. One active-low frame strobe and a 4-bit data nibble, sampled on each rising clock edge, carry every part of the cycle. The target checks the opening code and compares a select nibble with its own 4-bit ID strap. It then gathers a 28-bit address and a size code, and assembles one data byte. The whole cycle takes seventeen clocks.

Once the data is in, the target takes the bus for three clocks. It drives all-ones in the first, the sync code 0000b in the second and all-ones again in the third. In the fourth clock it releases the bus to the host. The bidirectional pins appear as a separate input nibble, output nibble and output enable, which a pad cell joins. A completed write is handed inward as a one-clock strobe with the captured address and byte. A cycle for another ID or with a wrong size code is dropped silently. The frame strobe going low again at any point restarts decoding.

Top module: `nwt_write_target`

## Requirements
- R1: A cycle opens only on a rising edge where `frame_n` is low and `bus_in` equals 1110b. Any other nibble seen with `frame_n` low leaves the target idle.
- R2: The nibble in the clock after the opening code is compared with `id_strap`. On a mismatch the target drives nothing and issues no write for that cycle.
- R3: The next seven nibbles form the 28-bit `wr_addr`, with the first nibble received placed in bits 27:24 and the seventh in bits 3:0.
- R4: The nibble after the address must be 0000b. Any other value abandons the cycle with no sync and no write.
- R5: The two data nibbles form `wr_data`, with the first received in bits 3:0 and the second in bits 7:4.
- R6: The clock after the data (clock 13) belongs to the host, and `bus_oe` stays low in it. In clock 14 the target asserts `bus_oe` and drives 1111b.
- R7: In clock 15 the target drives 0000b, and `wr_valid` is high for exactly that clock with the captured address and byte.
- R8: In clock 16 the target drives 1111b. In clock 17 `bus_oe` is low, and a new cycle may open on the very next edge.
- R9: `bus_oe` is low in every clock other than clocks 14 to 16 of an accepted cycle, and it is low out of reset.
- R10: `frame_n` low in the middle of a cycle abandons that cycle. If the nibble is 1110b, it is taken as a fresh opening code.
- R11: After a rejected ID or size, the target ignores every nibble while `frame_n` stays high, including 1110b, until `frame_n` is low with 1110b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| id_strap | input | 4 | Target identity compared with the select nibble |
| bus_in | input | 4 | Nibble seen on the shared bus |
| bus_out | output | 4 | Nibble the target drives when enabled |
| bus_oe | output | 1 | Output enable for the target's bus drivers |
| wr_valid | output | 1 | One-clock write request |
| wr_addr | output | 28 | Address of the write request |
| wr_data | output | 8 | Byte of the write request |

## Verification
Assertions check several rules on every cycle. The output enable is only ever high in the three target-owned states, and the host turnaround clock is never driven. The write strobe lasts one clock and only coincides with a driven 0000b. The bus is released after the final all-ones, a bad size sends the engine to its waiting state, and a low frame strobe always cancels driving on the next clock. Other behaviours can only be shown by the bench's scenarios, where a reference model is compared each clock: the nibble order of address and data, silence on a foreign ID, deafness to 1110b while the strobe is high, restart after an abort and back-to-back cycles.

// File: rtl/nwt_pkg.sv
package nwt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_SIZE,
        ST_DATA,
        ST_TAR_H,
        ST_TAR_T,
        ST_SYNC,
        ST_TAR_E,
        ST_WAIT
    } nwt_state_e;

endpackage

// File: rtl/nwt_addr_shift.sv
module nwt_addr_shift #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 7,
    localparam int AW   = NIB_W * NIBS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [NIB_W-1:0] nib,
    output logic [AW-1:0]    addr
);

    logic [AW-1:0] addr_d, addr_q;

    // Most significant nibble arrives first: shift toward the top.
    always_comb begin
        addr_d = addr_q;
        if (shift_en) begin
            addr_d = {addr_q[AW-NIB_W-1:0], nib};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/nwt_data_slots.sv
module nwt_data_slots #(
    parameter int NIB_W  = 4,
    parameter int NIBS   = 2,
    localparam int DW    = NIB_W * NIBS,
    localparam int SEL_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SEL_W-1:0] slot,
    input  logic [NIB_W-1:0] nib,
    output logic [DW-1:0]    data
);

    // Slot 0 is the least significant nibble and is filled first.
    for (genvar i = 0; i < NIBS; i++) begin : g_slot
        logic [NIB_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (load_en && (slot == SEL_W'(i))) begin
                slot_d = nib;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign data[i*NIB_W +: NIB_W] = slot_q;
    end

endmodule

// File: rtl/nwt_bus_drive.sv
module nwt_bus_drive #(
    parameter int              NIB_W     = 4,
    parameter logic [NIB_W-1:0] SYNC_CODE = '0,
    parameter logic [NIB_W-1:0] TAR_CODE  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  nwt_pkg::nwt_state_e   state_d,
    output logic                  drv_oe,
    output logic [NIB_W-1:0]      drv_nib
);
    import nwt_pkg::*;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] nib;
    } drv_t;

    drv_t drv_d, drv_q;

    // Registered from the next state so the pins change with the state.
    always_comb begin
        drv_d.oe  = 1'b0;
        drv_d.nib = TAR_CODE;
        unique case (state_d)
            ST_TAR_T: drv_d.oe = 1'b1;
            ST_SYNC: begin
                drv_d.oe  = 1'b1;
                drv_d.nib = SYNC_CODE;
            end
            ST_TAR_E: drv_d.oe = 1'b1;
            default: drv_d.oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.oe  <= 1'b0;
            drv_q.nib <= TAR_CODE;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign drv_oe  = drv_q.oe;
    assign drv_nib = drv_q.nib;

endmodule

// File: rtl/nwt_write_target.sv
module nwt_write_target #(
    parameter int               NIB_W      = 4,
    parameter int               ADDR_NIBS  = 7,
    parameter int               DATA_NIBS  = 2,
    parameter logic [NIB_W-1:0] START_CODE = 4'b1110,
    parameter logic [NIB_W-1:0] SIZE_CODE  = 4'b0000,
    parameter logic [NIB_W-1:0] SYNC_CODE  = 4'b0000,
    parameter logic [NIB_W-1:0] TAR_CODE   = 4'b1111,
    localparam int ADDR_W   = NIB_W * ADDR_NIBS,
    localparam int DATA_W   = NIB_W * DATA_NIBS,
    localparam int MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
    localparam int CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1,
    localparam int SLOT_W   = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  id_strap,
    input  logic [NIB_W-1:0]  bus_in,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import nwt_pkg::*;

    typedef struct packed {
        nwt_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             wr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic addr_shift;
    logic data_load;
    logic start_seen;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wr   = 1'b0;
        addr_shift = 1'b0;
        data_load  = 1'b0;
        start_seen = !frame_n && (bus_in == START_CODE);
        if (!frame_n) begin
            // Strobe low always restarts decoding, whatever the state.
            ctl_d.state = start_seen ? ST_SEL : ST_IDLE;
            ctl_d.cnt   = '0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE, ST_WAIT: ctl_d.state = ctl_q.state;
                ST_SEL: begin
                    ctl_d.cnt   = '0;
                    ctl_d.state = (bus_in == id_strap) ? ST_ADDR : ST_WAIT;
                end
                ST_ADDR: begin
                    addr_shift = 1'b1;
                    if (ctl_q.cnt == CNT_W'(ADDR_NIBS - 1)) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_SIZE;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                end
                ST_SIZE: begin
                    ctl_d.cnt   = '0;
                    ctl_d.state = (bus_in == SIZE_CODE) ? ST_DATA : ST_WAIT;
                end
                ST_DATA: begin
                    data_load = 1'b1;
                    if (ctl_q.cnt == CNT_W'(DATA_NIBS - 1)) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_TAR_H;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                end
                ST_TAR_H: ctl_d.state = ST_TAR_T;
                ST_TAR_T: begin
                    ctl_d.state = ST_SYNC;
                    ctl_d.wr    = 1'b1;
                end
                ST_SYNC:  ctl_d.state = ST_TAR_E;
                ST_TAR_E: ctl_d.state = ST_IDLE;
                default:  ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.wr    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    nwt_addr_shift #(
        .NIB_W (NIB_W),
        .NIBS  (ADDR_NIBS)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (addr_shift),
        .nib      (bus_in),
        .addr     (wr_addr)
    );

    nwt_data_slots #(
        .NIB_W (NIB_W),
        .NIBS  (DATA_NIBS)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (data_load),
        .slot    (ctl_q.cnt[SLOT_W-1:0]),
        .nib     (bus_in),
        .data    (wr_data)
    );

    nwt_bus_drive #(
        .NIB_W     (NIB_W),
        .SYNC_CODE (SYNC_CODE),
        .TAR_CODE  (TAR_CODE)
    ) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (ctl_d.state),
        .drv_oe  (bus_oe),
        .drv_nib (bus_out)
    );

    assign wr_valid = ctl_q.wr;

    // R9
    oe_owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (ctl_q.state inside {ST_TAR_T, ST_SYNC, ST_TAR_E}));

    // R6
    host_tar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_TAR_H) |-> !bus_oe);

    // R7
    wr_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (bus_oe && (bus_out == SYNC_CODE)));

    // R7
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R8
    tar_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && frame_n) |=> (bus_oe && (bus_out == TAR_CODE)));

    // R8
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == ST_TAR_E) && frame_n) |=> !bus_oe);

    // R4
    bad_size_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == ST_SIZE) && frame_n && (bus_in != SIZE_CODE))
        |=> ((ctl_q.state == ST_WAIT) && !bus_oe));

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (!bus_oe && !wr_valid));

endmodule

// File: tb/tb_nwt_write_target.sv
module tb_nwt_write_target;

    localparam logic [3:0] STRAP = 4'h5;

    logic        clk;
    logic        rst_n;
    logic        frame_n;
    logic        host_drv;
    logic [3:0]  host_nib;
    logic [3:0]  bus_line;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        wr_valid;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [27:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    string cur_req = "R9";
    bit done = 0;

    // reference model state
    int          k = 0;
    logic [27:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic        exp_oe = 0;
    logic [3:0]  exp_out = 4'hF;
    logic        exp_wr = 0;

    assign bus_line = bus_oe ? bus_out : (host_drv ? host_nib : 4'hF);

    nwt_write_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .id_strap (STRAP),
        .bus_in   (bus_line),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    initial clk = 0;
    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: counts position within the frame using host-side values.
    always @(posedge clk) begin
        logic [3:0] hl;
        hl = host_drv ? host_nib : 4'hF;
        if (!rst_n) begin
            k = 0;
        end else if (!frame_n) begin
            k = (hl == 4'hE) ? 1 : 0;
        end else if (k == 0) begin
            k = 0;
        end else if (k == 1) begin
            k = (hl == STRAP) ? 2 : 0;
        end else if (k <= 8) begin
            m_addr = {m_addr[23:0], hl};
            k++;
        end else if (k == 9) begin
            k = (hl == 4'h0) ? 10 : 0;
        end else if (k == 10) begin
            m_data[3:0] = hl;
            k = 11;
        end else if (k == 11) begin
            m_data[7:4] = hl;
            k = 12;
        end else if (k < 15) begin
            k++;
        end else begin
            k = 0;
        end
        exp_oe  = (k >= 13) && (k <= 15);
        exp_out = (k == 14) ? 4'h0 : 4'hF;
        exp_wr  = (k == 14);
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_oe == exp_oe, cur_req, bus_oe, exp_oe);
            if (exp_oe) chk(bus_out == exp_out, cur_req, bus_out, exp_out);
            chk(wr_valid == exp_wr, cur_req, wr_valid, exp_wr);
            if (exp_wr) begin
                chk(wr_addr == m_addr, cur_req, wr_addr, m_addr);
                chk(wr_data == m_data, cur_req, wr_data, m_data);
            end
            if (bus_oe && host_drv) chk(0, "R6", 1, 0);
            if (wr_valid) begin
                wr_cnt++;
                last_addr = wr_addr;
                last_data = wr_data;
            end
        end
    end

    task automatic step(input logic fr, input logic drv, input logic [3:0] nib);
        @(negedge clk);
        frame_n  = fr;
        host_drv = drv;
        host_nib = nib;
    endtask

    task automatic write_cycle(input logic [3:0] sel, input logic [27:0] a,
                               input logic [3:0] sz, input logic [7:0] d);
        step(0, 1, 4'hE);
        step(1, 1, sel);
        for (int i = 6; i >= 0; i--) step(1, 1, a[i*4 +: 4]);
        step(1, 1, sz);
        step(1, 1, d[3:0]);
        step(1, 1, d[7:4]);
        step(1, 1, 4'hF);
        repeat (4) step(1, 0, 4'h0);
    endtask

    task automatic settle();
        repeat (2) step(1, 0, 4'h0);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        rst_n = 0; frame_n = 1; host_drv = 0; host_nib = 4'h0;
        repeat (3) @(negedge clk);
        chk(bus_oe == 0, "R9", bus_oe, 0);
        chk(wr_valid == 0, "R9", wr_valid, 0);
        rst_n = 1;
        repeat (2) step(1, 0, 4'h0);

        // R3 R5 R7: nibble ordering and write request
        cur_req = "R3";
        base = wr_cnt;
        write_cycle(STRAP, 28'h1234567, 4'h0, 8'hA5);
        settle();
        chk(wr_cnt - base == 1, "R7", wr_cnt - base, 1);
        chk(last_addr == 28'h1234567, "R3", last_addr, 28'h1234567);
        chk(last_data == 8'hA5, "R5", last_data, 8'hA5);

        cur_req = "R5";
        base = wr_cnt;
        write_cycle(STRAP, 28'hFEDCBA9, 4'h0, 8'h3C);
        settle();
        chk(last_data == 8'h3C, "R5", last_data, 8'h3C);
        chk(last_addr == 28'hFEDCBA9, "R3", last_addr, 28'hFEDCBA9);

        // R2: foreign ID
        cur_req = "R2";
        base = wr_cnt;
        write_cycle(4'h3, 28'h0000111, 4'h0, 8'h77);
        settle();
        chk(wr_cnt - base == 0, "R2", wr_cnt - base, 0);

        // R4: bad size
        cur_req = "R4";
        base = wr_cnt;
        write_cycle(STRAP, 28'h0ABCDEF, 4'h1, 8'h11);
        settle();
        chk(wr_cnt - base == 0, "R4", wr_cnt - base, 0);

        // R11: waiting target deaf to 1110b with strobe high
        cur_req = "R11";
        base = wr_cnt;
        step(0, 1, 4'hE); step(1, 1, 4'h9);
        for (int i = 0; i < 10; i++) step(1, 1, 4'hE);
        step(1, 1, STRAP);
        for (int i = 0; i < 14; i++) step(1, 1, 4'h0);
        settle();
        chk(wr_cnt - base == 0, "R11", wr_cnt - base, 0);
        write_cycle(STRAP, 28'h5555AAA, 4'h0, 8'h5A);
        settle();
        chk(wr_cnt - base == 1, "R11", wr_cnt - base, 1);

        // R1: strobe low with a non-start nibble
        cur_req = "R1";
        base = wr_cnt;
        step(0, 1, 4'hF); step(1, 1, STRAP);
        for (int i = 0; i < 7; i++) step(1, 1, 4'h2);
        for (int i = 0; i < 8; i++) step(1, 1, 4'h0);
        settle();
        chk(wr_cnt - base == 0, "R1", wr_cnt - base, 0);

        // R10: abort mid-address, restart
        cur_req = "R10";
        base = wr_cnt;
        step(0, 1, 4'hE); step(1, 1, STRAP);
        step(1, 1, 4'h8); step(1, 1, 4'h8); step(1, 1, 4'h8);
        write_cycle(STRAP, 28'h0F0F0F0, 4'h0, 8'hC3);
        settle();
        chk(wr_cnt - base == 1, "R10", wr_cnt - base, 1);
        chk(last_addr == 28'h0F0F0F0, "R10", last_addr, 28'h0F0F0F0);

        // R8: back-to-back cycles
        cur_req = "R8";
        base = wr_cnt;
        write_cycle(STRAP, 28'h1111111, 4'h0, 8'h01);
        write_cycle(STRAP, 28'h2222222, 4'h0, 8'h02);
        settle();
        chk(wr_cnt - base == 2, "R8", wr_cnt - base, 2);
        chk(last_data == 8'h02, "R8", last_data, 8'h02);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule